// File: doc/BRIEF.md
# Quarter-Rate Quadrature-to-Real Up-Mixer

This block turns a stream of complex samples (in-phase and quadrature, each a signed word) into one stream of real samples at twice the complex rate. Each accepted complex sample is spread over two output slots, which doubles the rate. The block then mixes the result with a local oscillator at one quarter of the output rate. That oscillator's cosine and sine take only the values +1, -1 and 0, so the mix needs no multiplier: each output slot is simply the in-phase or the quadrature word, passed through or negated. Negation saturates, so the most negative word becomes the most positive one.

A sideband input picks the direction of the frequency shift. With it high, the complex content lands in the upper sideband of the real output. With it low, it lands in the lower sideband. A restart input forces the oscillator to phase zero, which lets an outside sequence align a chosen sample with the cosine peak. The clock runs at the output rate. A new complex sample is taken only on even oscillator phases. A sample offered on any other cycle is dropped and flagged. A two-bit operating-mode input enables the block only for code 2'b11.

Top module: `iq_real_upmix`

## Requirements
- R1: Only when `mode_i` equals 2'b11 is the block active. In any other mode, `in_ready_o` is 0, no output is produced on the following cycle, and the oscillator phase returns to 0.
- R2: While active, `in_ready_o` is high exactly on the cycles whose effective phase (0..3) is even. Without a restart, this accepts at most one complex sample every two clocks.
- R3: With `usb_i` = 1, a sample accepted on effective phase p produces two outputs. The first, on the next cycle, is +I if p = 0 and -I if p = 2. The second, one cycle later, is -Q if p = 0 and +Q if p = 2. The output therefore runs I, -Q, -I, +Q over phases 0..3.
- R4: With `usb_i` = 0, the I slot follows the same sign rule as R3, and the Q slot is +Q if p = 0 and -Q if p = 2. The output therefore runs I, +Q, -I, -Q.
- R5: An accepted sample's I slot appears with `out_valid_o` = 1 one cycle after acceptance, and its Q slot appears one cycle after that. The sideband value is the one present at acceptance. If a new sample is accepted in the Q-slot cycle (possible only after a restart), the new I slot replaces the pending Q slot.
- R6: Negating -32768 gives +32767. Every other value negates exactly.
- R7: When `sync_i` is high on an active cycle, that cycle's effective phase is 0, and the next cycle's phase is 1.
- R8: `in_valid_i` high while `in_ready_o` is low sets `ovr_o` on the next cycle. That sample is not used, and it produces no output.
- R9: In a cycle with no output slot due, `out_valid_o` is 0 and `out_data_o` is 0.
- R10: During and right after reset, `out_valid_o`, `out_data_o` and `ovr_o` are 0, and the phase is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at the output sample rate |
| rst_i | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Operating mode; 2'b11 enables the block |
| usb_i | input | 1 | 1: input becomes the upper sideband; 0: the lower sideband |
| sync_i | input | 1 | Forces the current cycle to oscillator phase 0 |
| in_valid_i | input | 1 | A complex sample is offered |
| i_data_i | input | DW | Signed in-phase word |
| q_data_i | input | DW | Signed quadrature word |
| in_ready_o | output | 1 | The sample offered this cycle will be taken |
| out_valid_o | output | 1 | `out_data_o` holds a real sample |
| out_data_o | output | DW | Signed real output sample |
| ovr_o | output | 1 | A sample was offered on the previous cycle while not ready |

## Verification
The I slot of an accepted sample is due on the first clock after acceptance, and its Q slot on the second. The overrun flag is due on the first clock after the refused offer. `in_ready_o` is combinational and is due in the same cycle. The driver settles the inputs just after a falling edge and checks readiness in that cycle. It then enqueues exactly one expected output word per clock, derived from its own phase model. The monitor samples on the next falling edge, after the one register stage has updated. This means every output, idle slots included, is compared in the cycle the timing rule names.

// File: rtl/upm_pkg.sv
package upm_pkg;
  localparam int          PH_W    = 2;
  localparam logic [1:0]  MODE_QR = 2'b11;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_I    = 2'd1,
    SRC_Q    = 2'd2
  } out_src_e;
endpackage

// File: rtl/upm_phase.sv
module upm_phase #(
  parameter int PW = 2
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          active_i,
  input  logic          sync_i,
  output logic [PW-1:0] cur_ph_o
);
  logic [PW-1:0] ph_q;

  // The restart overrides the stored phase within the same cycle.
  assign cur_ph_o = sync_i ? '0 : ph_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !active_i) ph_q <= '0;
    else                    ph_q <= cur_ph_o + 1'b1;
  end

  // R7: a restart on an active cycle leaves the oscillator at phase 1 next.
  a_r7_sync_restart: assert property (@(posedge clk_i) disable iff (rst_i)
    (active_i && sync_i) |=> (ph_q == PW'(1)));

  // R1: inactivity parks the phase at zero.
  a_r1_phase_parked: assert property (@(posedge clk_i) disable iff (rst_i)
    !active_i |=> (ph_q == '0));
endmodule

// File: rtl/upm_signsel.sv
module upm_signsel #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] x_i,
  input  logic                 neg_i,
  output logic signed [DW-1:0] y_o
);
  localparam logic signed [DW-1:0] S_MIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [DW-1:0] S_MAX = {1'b0, {(DW-1){1'b1}}};

  always_comb begin
    if (!neg_i)          y_o = x_i;
    else if (x_i == S_MIN) y_o = S_MAX;
    else                 y_o = -x_i;
  end

  // R6: a negated word never comes out as the most negative value.
  always_comb begin
    if (neg_i) a_r6_sat_neg: assert (y_o != S_MIN);
  end
endmodule

// File: rtl/iq_real_upmix.sv
module iq_real_upmix #(
  parameter int DW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic [1:0]           mode_i,
  input  logic                 usb_i,
  input  logic                 sync_i,
  input  logic                 in_valid_i,
  input  logic signed [DW-1:0] i_data_i,
  input  logic signed [DW-1:0] q_data_i,
  output logic                 in_ready_o,
  output logic                 out_valid_o,
  output logic signed [DW-1:0] out_data_o,
  output logic                 ovr_o
);
  import upm_pkg::*;

  logic                 active;
  logic                 accept;
  logic [PH_W-1:0]      cur_ph;
  logic signed [DW-1:0] q_hold;
  logic                 q_neg;
  logic                 q_pend;
  logic signed [DW-1:0] i_mixed;
  logic signed [DW-1:0] q_mixed;
  out_src_e             src;

  assign active = (mode_i == MODE_QR);

  upm_phase #(.PW(PH_W)) u_phase (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .active_i (active),
    .sync_i   (sync_i),
    .cur_ph_o (cur_ph)
  );

  assign in_ready_o = active && !cur_ph[0];
  assign accept     = in_valid_i && in_ready_o;

  // The cosine leg is -1 at phase 2.
  upm_signsel #(.DW(DW)) u_sign_i (
    .x_i   (i_data_i),
    .neg_i (cur_ph[1]),
    .y_o   (i_mixed)
  );

  upm_signsel #(.DW(DW)) u_sign_q (
    .x_i   (q_hold),
    .neg_i (q_neg),
    .y_o   (q_mixed)
  );

  always_comb begin
    if (!active)     src = SRC_NONE;
    else if (accept) src = SRC_I;
    else if (q_pend) src = SRC_Q;
    else             src = SRC_NONE;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      q_pend      <= 1'b0;
      q_hold      <= '0;
      q_neg       <= 1'b0;
      ovr_o       <= 1'b0;
    end else begin
      ovr_o <= in_valid_i && !in_ready_o;
      case (src)
        SRC_I: begin
          out_valid_o <= 1'b1;
          out_data_o  <= i_mixed;
          q_pend      <= 1'b1;
          q_hold      <= q_data_i;
          // The sine leg sign depends on the sideband and the half cycle.
          q_neg       <= usb_i ^ cur_ph[1];
        end
        SRC_Q: begin
          out_valid_o <= 1'b1;
          out_data_o  <= q_mixed;
          q_pend      <= 1'b0;
        end
        default: begin
          out_valid_o <= 1'b0;
          out_data_o  <= '0;
          q_pend      <= q_pend && active;
        end
      endcase
    end
  end

  // R1: an inactive mode yields no output on the next cycle.
  a_r1_idle_out: assert property (@(posedge clk_i) disable iff (rst_i)
    !active |=> !out_valid_o);

  // R2: no two acceptances in a row unless a restart realigns the phase.
  a_r2_one_per_two: assert property (@(posedge clk_i) disable iff (rst_i)
    accept |=> (!accept || sync_i));

  // R5: the I slot follows acceptance by one cycle.
  a_r5_i_slot: assert property (@(posedge clk_i) disable iff (rst_i)
    accept |=> out_valid_o);

  // R5: the Q slot follows one cycle later when nothing displaces it.
  a_r5_q_slot: assert property (@(posedge clk_i) disable iff (rst_i)
    accept ##1 (active && !accept) |=> out_valid_o);

  // R8: a refused offer raises the flag and produces no output.
  a_r8_overrun: assert property (@(posedge clk_i) disable iff (rst_i)
    (in_valid_i && !active) |=> (ovr_o && !out_valid_o));

  // R9: idle slots carry zero.
  a_r9_zero_idle: assert property (@(posedge clk_i) disable iff (rst_i)
    !out_valid_o |-> (out_data_o == '0));
endmodule

// File: tb/iq_real_upmix_bench.sv
module iq_real_upmix_bench;
  typedef struct {
    logic                v;
    logic signed [15:0]  d;
    logic                o;
    string               tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = 2'b11;
  logic usb = 1'b1, sync = 1'b0, in_valid = 1'b0;
  logic signed [15:0] i_d = '0, q_d = '0;
  logic in_ready, out_valid, ovr;
  logic signed [15:0] out_data;

  int n_chk = 0, n_bad = 0;
  exp_t sbq[$];
  logic [1:0] m_ph = 2'd0;
  logic m_qp = 1'b0;
  logic signed [15:0] m_qv = '0;
  string m_qtag = "";
  bit done = 0;

  always #2 clk = ~clk;

  iq_real_upmix u_iq_real_upmix (
    .clk_i(clk), .rst_i(rst), .mode_i(mode), .usb_i(usb), .sync_i(sync),
    .in_valid_i(in_valid), .i_data_i(i_d), .q_data_i(q_d),
    .in_ready_o(in_ready), .out_valid_o(out_valid), .out_data_o(out_data),
    .ovr_o(ovr)
  );

  function automatic logic signed [15:0] sneg(input logic signed [15:0] x);
    return (x == 16'sh8000) ? 16'sh7fff : -x;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Applies one cycle of stimulus and enqueues the output expected after it.
  task automatic drv(input logic [1:0] md, input logic v, input logic sy, input logic u,
                     input logic signed [15:0] iv, input logic signed [15:0] qv);
    logic [1:0] eff;
    logic act, rdy, acc;
    exp_t e;
    mode = md; in_valid = v; sync = sy; usb = u; i_d = iv; q_d = qv;
    #1;
    eff = sy ? 2'd0 : m_ph;
    act = (md == 2'b11);
    rdy = act && (eff == 2'd0 || eff == 2'd2);
    acc = v && rdy;
    chk(in_ready == rdy, act ? (sy ? "R7" : "R2") : "R1", in_ready, rdy);
    e.o = v && !rdy;
    e.v = 1'b0; e.d = '0;
    e.tag = !act ? "R1" : (e.o ? "R8" : "R9");
    if (!act) m_qp = 1'b0;
    else if (acc) begin
      e.v = 1'b1;
      e.d = (eff == 2'd2) ? sneg(iv) : iv;
      e.tag = (iv == 16'sh8000 && eff == 2'd2) ? "R6" : (sy ? "R7" : "R5");
      // Q slot sign: USB runs -Q then +Q, LSB runs +Q then -Q.
      if (u) m_qv = (eff == 2'd0) ? sneg(qv) : qv;
      else   m_qv = (eff == 2'd0) ? qv : sneg(qv);
      m_qtag = (qv == 16'sh8000) ? "R6" : (u ? "R3" : "R4");
      m_qp = 1'b1;
    end else if (m_qp) begin
      e.v = 1'b1; e.d = m_qv; e.tag = m_qtag; m_qp = 1'b0;
    end
    m_ph = act ? eff + 2'd1 : 2'd0;
    sbq.push_back(e);
    @(negedge clk);
  endtask

  // Scoreboard monitor: one expectation per falling edge.
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      chk(out_valid == e.v, e.tag, out_valid, e.v);
      chk(ovr == e.o, e.o ? "R8" : e.tag, ovr, e.o);
      chk(out_data == e.d, e.tag, out_data, e.d);
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10", out_valid, 0);
    chk(out_data == 16'sd0, "R10", out_data, 0);
    chk(ovr == 1'b0, "R10", ovr, 0);
    rst = 1'b0;
    // R3: upper sideband streaming
    for (int k = 0; k < 6; k++) begin
      drv(2'b11, 1, 0, 1, 16'(100 + k), 16'(-200 - k));
      drv(2'b11, 0, 0, 1, 0, 0);
    end
    // R4: lower sideband streaming
    for (int k = 0; k < 6; k++) begin
      drv(2'b11, 1, 0, 0, 16'(1000 * k - 2500), 16'(300 + 7 * k));
      drv(2'b11, 0, 0, 0, 0, 0);
    end
    // R9: gaps in the input
    drv(2'b11, 0, 0, 1, 0, 0); drv(2'b11, 0, 0, 1, 0, 0);
    drv(2'b11, 1, 0, 1, 16'sd5, 16'sd6); drv(2'b11, 0, 0, 1, 0, 0);
    drv(2'b11, 0, 0, 1, 0, 0); drv(2'b11, 0, 0, 1, 0, 0);
    // R8: offer on an odd phase
    drv(2'b11, 1, 0, 1, 16'sd7, 16'sd8);
    drv(2'b11, 1, 0, 1, 16'sd9, 16'sd10);
    drv(2'b11, 1, 0, 1, 16'sd11, 16'sd12);
    drv(2'b11, 0, 0, 1, 0, 0);
    // R7: restart realigns phase, dropping a pending Q slot
    drv(2'b11, 1, 0, 1, 16'sd21, 16'sd22);
    drv(2'b11, 1, 1, 1, 16'sd23, 16'sd24);
    drv(2'b11, 0, 0, 1, 0, 0);
    drv(2'b11, 1, 0, 1, 16'sd25, 16'sd26);
    drv(2'b11, 0, 1, 1, 0, 0);
    drv(2'b11, 0, 0, 1, 0, 0);
    // R6: most negative words on negating slots, both sidebands
    for (int s = 0; s < 2; s++) begin
      drv(2'b11, 1, 1, s[0], 16'sh8000, 16'sh8000);
      drv(2'b11, 0, 0, s[0], 0, 0);
      drv(2'b11, 1, 0, s[0], 16'sh8000, 16'sh8000);
      drv(2'b11, 0, 0, s[0], 0, 0);
    end
    // R1: other modes refuse input and stay silent, then restart at phase 0
    drv(2'b11, 1, 1, 1, 16'sd31, 16'sd32);
    drv(2'b01, 1, 0, 1, 16'sd33, 16'sd34);
    drv(2'b00, 0, 0, 1, 0, 0);
    drv(2'b10, 1, 0, 1, 16'sd35, 16'sd36);
    drv(2'b11, 1, 0, 1, 16'sd37, 16'sd38);
    drv(2'b11, 0, 0, 1, 0, 0);
    drv(2'b11, 0, 0, 1, 0, 0);
    drv(2'b11, 0, 0, 1, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule